// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an 8-bit asynchronous parallel flash part. A client hands it one request at a time (program a byte, erase a 4 KiB sector, erase the whole array, or fetch the identification codes) over a valid/ready handshake. The block then drives the flash address, data and three active-low strobes through the protected unlock write sequence for that request, and for program and erase it polls the target location until the status toggle bit settles.

Every flash bus cycle is built from whole clock cycles. The strobe-low, strobe-high, read-access and identification-settle windows are given in nanoseconds as parameters and rounded up to clock counts. Completion is decided only from a run of agreeing reads, so a read that lands exactly on the internal completion edge cannot end polling early. A per-operation bound on the number of polling reads turns a flash that never finishes into a reported error.

Back-pressure is simple: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While an operation runs, `req_ready` stays low and anything on the request pins is ignored. The end of each operation is reported by a one-cycle `done` pulse, with `err` valid in the same cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: Request code 0 (program) issues writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), (request address, request data) in that order, then reads only the request address while polling.
- R2: Request code 1 (sector erase) issues (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), (request address,0x30). Request code 2 (chip erase) issues the same first five writes and ends with (0x5555,0x10). Both then poll the request address.
- R3: A polling read counts as an apparent finish when its bit 6 equals that of the previous polling read. The operation finishes only when the next two polling reads also agree, so done follows the first read that ends a run of four reads with equal bit 6. A mismatch anywhere restarts the run and polling goes on.
- R4: If no finish is confirmed within the per-operation bound of polling reads, the operation ends with err=1 right after exactly that many polling reads.
- R5: The write strobe stays low for at least ceil(max(40 ns, 40 ns)/clock period) cycles, with address and data held stable for that whole time. Between writes of one sequence it stays high for at least ceil(30 ns/clock period) cycles. Output enable is never low at the same time as the write strobe. Chip enable is low whenever either strobe is low.
- R6: Request code 3 (identification) writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x90). It then leaves the bus quiet for at least ceil(150 ns/clock period) cycles, reads address 0 into `id_mfr` and address 1 into `id_dev`, and writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xF0). done follows no sooner than that same quiet time after the last write.
- R7: `req_ready` is high exactly when the block is idle. It falls in the cycle after an accepted request and rises again with `done`. Request pins driven while busy cause no bus activity. The bus is quiet while idle.
- R8: `done` is a single-cycle pulse in the first cycle `req_ready` is high again. `err` is 0 on every operation that completed normally.
- R9: After reset, `req_ready`=1, `done`=0, and all three strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identification |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Polling bound exceeded, valid with done |
| id_mfr | output | 8 | Manufacturer code from the last identification |
| id_dev | output | 8 | Device code from the last identification |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |

## Verification
A wrong step index or request code shows up as a wrong address/data pair at the very next write-strobe rising edge, so it appears within one bus cycle of the error. A poll tracker that loses its run count or bound shows up only at the end of the operation, as `done` arriving after the wrong number of polling reads or with the wrong `err`. A stall in the toggle stream is injected to prove that one agreeing pair is not enough. A handshake fault shows as `req_ready` differing from the idle state in the same cycle, or as extra strobes while a request is held during a busy operation.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_ID = 2'd3} op_e;
  typedef enum logic [2:0] {K_WR, K_RD0, K_RD1, K_WAIT, K_POLL, K_END} kind_e;
  typedef enum logic [1:0] {B_IDLE, B_WLO, B_WHI, B_RD} bus_st_e;
  typedef enum logic [2:0] {T_IDLE, T_ISSUE, T_BUS, T_WAIT, T_FIN} top_st_e;

  typedef struct packed {
    kind_e       kind;
    logic        req_a;   // address comes from the request
    logic        req_d;   // data comes from the request
    logic [14:0] ua;
    logic [7:0]  ud;
  } step_t;

  function automatic step_t mk(kind_e k, logic ra, logic rd, logic [14:0] a, logic [7:0] d);
    step_t s;
    s.kind = k; s.req_a = ra; s.req_d = rd; s.ua = a; s.ud = d;
    return s;
  endfunction

  // Step i of the bus program for operation op.
  function automatic step_t step_of(op_e op, logic [3:0] i);
    logic [7:0] third;
    step_t s;
    third = (op == OP_PROG) ? 8'hA0 : (op == OP_ID) ? 8'h90 : 8'h80;
    s = mk(K_END, 1'b0, 1'b0, 15'h0, 8'h00);
    case (i)
      4'd0: s = mk(K_WR, 1'b0, 1'b0, 15'h5555, 8'hAA);
      4'd1: s = mk(K_WR, 1'b0, 1'b0, 15'h2AAA, 8'h55);
      4'd2: s = mk(K_WR, 1'b0, 1'b0, 15'h5555, third);
      default: begin
        case (op)
          OP_PROG: case (i)
            4'd3: s = mk(K_WR, 1'b1, 1'b1, 15'h0, 8'h00);
            4'd4: s = mk(K_POLL, 1'b1, 1'b0, 15'h0, 8'h00);
            default: ;
          endcase
          OP_SECT, OP_CHIP: case (i)
            4'd3: s = mk(K_WR, 1'b0, 1'b0, 15'h5555, 8'hAA);
            4'd4: s = mk(K_WR, 1'b0, 1'b0, 15'h2AAA, 8'h55);
            4'd5: s = (op == OP_SECT) ? mk(K_WR, 1'b1, 1'b0, 15'h0, 8'h30)
                                      : mk(K_WR, 1'b0, 1'b0, 15'h5555, 8'h10);
            4'd6: s = mk(K_POLL, 1'b1, 1'b0, 15'h0, 8'h00);
            default: ;
          endcase
          default: case (i)
            4'd3: s = mk(K_WAIT, 1'b0, 1'b0, 15'h0, 8'h00);
            4'd4: s = mk(K_RD0, 1'b0, 1'b0, 15'h0, 8'h00);
            4'd5: s = mk(K_RD1, 1'b0, 1'b0, 15'h0, 8'h00);
            4'd6: s = mk(K_WR, 1'b0, 1'b0, 15'h5555, 8'hAA);
            4'd7: s = mk(K_WR, 1'b0, 1'b0, 15'h2AAA, 8'h55);
            4'd8: s = mk(K_WR, 1'b0, 1'b0, 15'h5555, 8'hF0);
            4'd9: s = mk(K_WAIT, 1'b0, 1'b0, 15'h0, 8'h00);
            default: ;
          endcase
        endcase
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fseq_bus_engine.sv
module fseq_bus_engine #(
  parameter int AW      = 19,
  parameter int WLO_CYC = 8,
  parameter int WHI_CYC = 6,
  parameter int RD_CYC  = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce_n
);
  import fseq_pkg::*;
  localparam int M1   = (WLO_CYC > WHI_CYC) ? WLO_CYC : WHI_CYC;
  localparam int MAXC = (M1 > RD_CYC) ? M1 : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bus_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= B_IDLE; cnt <= '0; ack <= 1'b0;
      rdata <= '0; fl_addr <= '0; fl_wdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          fl_addr  <= addr;
          fl_wdata <= wdata;
          st       <= wr ? B_WLO : B_RD;
          cnt      <= wr ? CW'(WLO_CYC - 1) : CW'(RD_CYC - 1);
        end
        B_WLO: if (cnt == '0) begin
          st <= B_WHI; cnt <= CW'(WHI_CYC - 1);
        end else cnt <= cnt - 1'b1;
        B_WHI: if (cnt == '0) begin
          st <= B_IDLE; ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          st <= B_IDLE; ack <= 1'b1; rdata <= fl_rdata;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign fl_we_n = (st != B_WLO);
  assign fl_oe_n = (st != B_RD);
  assign fl_ce_n = (st == B_IDLE);
endmodule

// File: rtl/fseq_poll_track.sv
module fseq_poll_track #(
  parameter int PLW = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           sample,
  input  logic           bit6,
  input  logic [PLW-1:0] limit,
  output logic           confirm,
  output logic           expired
);
  logic           prev, has_prev;
  logic [1:0]     run;
  logic [PLW-1:0] reads;
  logic           same;

  assign same    = has_prev && (bit6 == prev);
  assign confirm = sample && same && (run == 2'd2);
  assign expired = sample && !confirm && ({1'b0, reads} + 1'b1 >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev <= 1'b0; has_prev <= 1'b0; run <= '0; reads <= '0;
    end else if (sample) begin
      prev     <= bit6;
      has_prev <= 1'b1;
      run      <= same ? run + 2'd1 : 2'd0;
      reads    <= reads + 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW         = 19,
  parameter int CLK_NS     = 5,
  parameter int WP_NS      = 40,
  parameter int DS_NS      = 40,
  parameter int WPH_NS     = 30,
  parameter int RD_NS      = 90,
  parameter int IDW_NS     = 150,
  parameter int PLW        = 18,
  parameter int PROG_POLLS = 2048,
  parameter int SECT_POLLS = 65536,
  parameter int CHIP_POLLS = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          err,
  output logic [7:0]    id_mfr,
  output logic [7:0]    id_dev,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce_n
);
  import fseq_pkg::*;
  localparam int WLO_NS  = (WP_NS > DS_NS) ? WP_NS : DS_NS;
  localparam int WLO_CYC = (WLO_NS + CLK_NS - 1) / CLK_NS;
  localparam int WHI_CYC = (WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC  = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int IDW_CYC = (IDW_NS + CLK_NS - 1) / CLK_NS;
  localparam int WW      = $clog2(IDW_CYC + 1);

  top_st_e       st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [3:0]    idx;
  logic [WW-1:0] wcnt;
  logic          err_q, done_q;
  logic [7:0]    mfr_q, dev_q;
  step_t         s;
  logic          eng_start, eng_ack;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata, eng_rdata;
  logic          confirm, expired, sample;
  logic [PLW-1:0] limit;

  assign s = step_of(op_q, idx);

  always_comb begin
    case (s.kind)
      K_RD0:   eng_addr = '0;
      K_RD1:   eng_addr = AW'(1);
      default: eng_addr = s.req_a ? addr_q : AW'(s.ua);
    endcase
    case (op_q)
      OP_PROG: limit = PLW'(PROG_POLLS);
      OP_SECT: limit = PLW'(SECT_POLLS);
      default: limit = PLW'(CHIP_POLLS);
    endcase
  end
  assign eng_wdata = s.req_d ? data_q : s.ud;
  assign eng_start = (st == T_ISSUE) &&
                     (s.kind == K_WR || s.kind == K_RD0 || s.kind == K_RD1 || s.kind == K_POLL);
  assign sample    = eng_ack && (st == T_BUS) && (s.kind == K_POLL);

  fseq_bus_engine #(.AW(AW), .WLO_CYC(WLO_CYC), .WHI_CYC(WHI_CYC), .RD_CYC(RD_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .wr(s.kind == K_WR),
    .addr(eng_addr), .wdata(eng_wdata), .ack(eng_ack), .rdata(eng_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n));

  fseq_poll_track #(.PLW(PLW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(st == T_IDLE), .sample(sample),
    .bit6(eng_rdata[6]), .limit(limit), .confirm(confirm), .expired(expired));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; op_q <= OP_PROG; addr_q <= '0; data_q <= '0; idx <= '0;
      wcnt <= '0; err_q <= 1'b0; done_q <= 1'b0; mfr_q <= '0; dev_q <= '0;
    end else begin
      done_q <= (st == T_FIN);
      case (st)
        T_IDLE: if (req_valid) begin
          op_q <= op_e'(req_op); addr_q <= req_addr; data_q <= req_data;
          idx <= '0; err_q <= 1'b0; st <= T_ISSUE;
        end
        T_ISSUE: case (s.kind)
          K_WAIT:  begin wcnt <= WW'(IDW_CYC - 1); st <= T_WAIT; end
          K_END:   st <= T_FIN;
          default: st <= T_BUS;
        endcase
        T_BUS: if (eng_ack) begin
          if (s.kind == K_RD0) mfr_q <= eng_rdata;
          if (s.kind == K_RD1) dev_q <= eng_rdata;
          if (s.kind != K_POLL || confirm) begin
            idx <= idx + 4'd1; st <= T_ISSUE;
          end else if (expired) begin
            err_q <= 1'b1; st <= T_FIN;
          end else st <= T_ISSUE;
        end
        T_WAIT: if (wcnt == '0) begin
          idx <= idx + 4'd1; st <= T_ISSUE;
        end else wcnt <= wcnt - 1'b1;
        default: st <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (st == T_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign id_mfr    = mfr_q;
  assign id_dev    = dev_q;
endmodule

// File: rtl/fseq_checks.sv
module fseq_checks #(
  parameter int AW     = 19,
  parameter int CLK_NS = 5,
  parameter int WP_NS  = 40,
  parameter int DS_NS  = 40,
  parameter int WPH_NS = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic          fl_ce_n,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata
);
  localparam int LO_NS  = (WP_NS > DS_NS) ? WP_NS : DS_NS;
  localparam int LO_MIN = (LO_NS + CLK_NS - 1) / CLK_NS;
  localparam int HI_MIN = (WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RW     = $clog2(LO_MIN + HI_MIN + 2);
  localparam logic [RW-1:0] SAT = {RW{1'b1}};

  logic [RW-1:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0; hi_run <= SAT;
    end else begin
      lo_run <= fl_we_n ? '0 : ((lo_run == SAT) ? SAT : lo_run + 1'b1);
      hi_run <= !fl_we_n ? '0 : ((hi_run == SAT) ? SAT : hi_run + 1'b1);
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) fl_we_n || fl_oe_n);
  p_ce_cover_r5: assert property (@(posedge clk) disable iff (!rst_n) (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_we_n) |-> lo_run >= RW'(LO_MIN));
  p_we_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) $fell(fl_we_n) |-> hi_run >= RW'(HI_MIN));
  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));
  p_accept_drop_r7: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n) (req_ready && !done) |-> fl_ce_n);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready);
endmodule

bind flash_cmd_seq fseq_checks #(.AW(AW), .CLK_NS(CLK_NS), .WP_NS(WP_NS), .DS_NS(DS_NS), .WPH_NS(WPH_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .done(done),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n), .fl_addr(fl_addr), .fl_wdata(fl_wdata));

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 19;
  localparam int WLO_CYC = 8;   // ceil(40/5)
  localparam int WHI_CYC = 6;   // ceil(30/5)
  localparam int IDW_CYC = 30;  // ceil(150/5)
  localparam int P_LIM = 16, S_LIM = 24, C_LIM = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done, err;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0, fl_addr;
  logic [7:0] req_data = '0, id_mfr, id_dev, fl_wdata, fl_rdata;
  logic fl_we_n, fl_oe_n, fl_ce_n;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .PROG_POLLS(P_LIM), .SECT_POLLS(S_LIM), .CHIP_POLLS(C_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .done(done), .err(err), .id_mfr(id_mfr),
    .id_dev(id_dev), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n));

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural flash
  logic [7:0] mem [0:255];
  int busy_left = 0, busy_reads = 0, stall_at = 0, wcnt = 0;
  logic tog = 1'b0, id_mode = 1'b0;
  always_comb begin
    if (busy_left > 0) fl_rdata = {~mem[fl_addr[7:0]][7], tog, 6'h00};
    else if (id_mode) fl_rdata = (fl_addr == 0) ? 8'hBF : (fl_addr == 1) ? 8'hD7 : 8'h00;
    else fl_rdata = mem[fl_addr[7:0]];
  end

  // per-operation context and reference state
  int cur_op = 0, busy_cfg = 0, limit = 0, poll_reads = 0, run = 0, confirm_at = 0;
  int id_reads = 0, lo_run = 0, hi_run = 0, since_we = 1000, op_writes = 0;
  logic exp_err = 1'b0, exp_ready = 1'b1, prev_b6 = 1'b0, bad_stable = 1'b0;
  logic pwe = 1'b1, poe = 1'b1, pdone = 1'b0;
  logic [AW-1:0] target = '0, cap_a = '0, rd_addr = '0;
  logic [7:0] cap_d = '0, last_rd = '0;
  logic [AW-1:0] exp_a[$];
  logic [7:0] exp_d[$];
  string tag = "R1";

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  always @(posedge clk) if (rst_n && req_valid && req_ready) exp_ready = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (done) exp_ready = 1'b1;
    chk(req_ready === exp_ready, "R7 ready", req_ready, exp_ready);
    chk(fl_we_n || fl_oe_n, "R5 strobe overlap", {fl_we_n, fl_oe_n}, 2'b11);
    if (!fl_we_n || !fl_oe_n) chk(!fl_ce_n, "R5 chip enable", fl_ce_n, 0);
    since_we++;
    if (pwe && !fl_we_n) begin
      if (op_writes > 0) chk(hi_run >= WHI_CYC, "R5 gap", hi_run, WHI_CYC);
      cap_a = fl_addr; cap_d = fl_wdata; lo_run = 0; bad_stable = 1'b0;
    end
    if (!fl_we_n) begin
      lo_run++;
      if (fl_addr !== cap_a || fl_wdata !== cap_d) bad_stable = 1'b1;
    end else hi_run++;
    if (!pwe && fl_we_n) begin
      chk(lo_run >= WLO_CYC, "R5 width", lo_run, WLO_CYC);
      chk(!bad_stable, "R5 stable", bad_stable, 0);
      if (exp_a.size() == 0) chk(1'b0, {tag, " extra write"}, cap_a, 0);
      else begin
        chk(cap_a == exp_a[0] && cap_d == exp_d[0], tag, {cap_a, cap_d}, {exp_a[0], exp_d[0]});
        void'(exp_a.pop_front()); void'(exp_d.pop_front());
      end
      op_writes++; wcnt++; hi_run = 0; since_we = 0;
      if (cur_op == 0 && wcnt == 4) begin mem[cap_a[7:0]] &= cap_d; busy_left = busy_cfg; end
      if ((cur_op == 1 || cur_op == 2) && wcnt == 6) begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        busy_left = busy_cfg;
      end
      if (cur_op == 3 && wcnt == 3) id_mode = 1'b1;
      if (cur_op == 3 && wcnt == 6) id_mode = 1'b0;
    end
    if (poe && !fl_oe_n) begin
      rd_addr = fl_addr;
      if (cur_op == 3 && id_reads == 0) chk(since_we >= IDW_CYC, "R6 entry wait", since_we, IDW_CYC);
    end
    if (!fl_oe_n) last_rd = fl_rdata;
    if (!poe && fl_oe_n) begin
      if (cur_op == 3) id_reads++;
      else begin
        chk(rd_addr == target, {tag, " poll address"}, rd_addr, target);
        poll_reads++;
        if (poll_reads > 1 && last_rd[6] == prev_b6) run++; else run = 0;
        prev_b6 = last_rd[6];
        if (run == 3 && confirm_at == 0) confirm_at = poll_reads;
      end
      if (busy_left > 0) begin
        busy_reads++;
        if (busy_reads != stall_at) tog = ~tog;
        busy_left--;
      end
    end
    if (done) begin
      chk(!pdone, "R8 pulse", pdone, 0);
      chk(exp_a.size() == 0, {tag, " missing writes"}, exp_a.size(), 0);
      if (cur_op == 3) begin
        chk(id_mfr == 8'hBF, "R6 mfr", id_mfr, 8'hBF);
        chk(id_dev == 8'hD7, "R6 dev", id_dev, 8'hD7);
        chk(id_reads == 2, "R6 reads", id_reads, 2);
        chk(since_we >= IDW_CYC, "R6 exit wait", since_we, IDW_CYC);
        chk(!err, "R8 err", err, 0);
      end else if (exp_err) begin
        chk(err, "R4 err", err, 1);
        chk(poll_reads == limit, "R4 reads", poll_reads, limit);
      end else begin
        chk(!err, "R8 err", err, 0);
        chk(confirm_at > 0 && poll_reads == confirm_at, "R3 confirm", poll_reads, confirm_at);
      end
    end
    pwe = fl_we_n; poe = fl_oe_n; pdone = done;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int busy, input int stall, input logic e_err, input logic junk);
    int n;
    cur_op = op; target = a; busy_cfg = busy; stall_at = stall; exp_err = e_err;
    limit = (op == 0) ? P_LIM : (op == 1) ? S_LIM : C_LIM;
    poll_reads = 0; run = 0; confirm_at = 0; id_reads = 0; op_writes = 0; wcnt = 0;
    busy_left = 0; busy_reads = 0;
    tag = (op == 0) ? "R1" : (op == 3) ? "R6" : "R2";
    push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55);
    case (op)
      0: begin push(19'h05555, 8'hA0); push(a, d); end
      1, 2: begin
        push(19'h05555, 8'h80); push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55);
        if (op == 1) push(a, 8'h30); else push(19'h05555, 8'h10);
      end
      default: begin
        push(19'h05555, 8'h90); push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55); push(19'h05555, 8'hF0);
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin  // R7: held request while busy must be ignored
      req_op = 2'd2; req_addr = 19'h00077; req_data = 8'h11;
      repeat (150) @(negedge clk);
    end
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9 handshake", {req_ready, done}, 2'b10);
    chk({fl_we_n, fl_oe_n, fl_ce_n} == 3'b111, "R9 strobes", {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9 after reset", {req_ready, done}, 2'b10);
    run_op(0, 19'h00123, 8'h5A, 5, 0, 1'b0, 1'b0);   // R1 R3
    run_op(0, 19'h00045, 8'h3C, 0, 0, 1'b0, 1'b0);   // R3 no busy reads
    run_op(0, 19'h00067, 8'hB7, 7, 2, 1'b0, 1'b0);   // R3 stalled toggle
    run_op(1, 19'h02345, 8'h00, 9, 0, 1'b0, 1'b1);   // R2 R7 held request
    run_op(2, 19'h00000, 8'h00, 12, 0, 1'b0, 1'b0);  // R2 chip
    run_op(3, 19'h00000, 8'h00, 0, 0, 1'b0, 1'b0);   // R6
    run_op(0, 19'h00010, 8'h81, 1000, 0, 1'b1, 1'b0); // R4 timeout
    run_op(0, 19'h00011, 8'h42, 3, 0, 1'b0, 1'b0);   // recovery, R8
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule